// File: doc/BRIEF.md
# Radix Page Access Permission Checker

This block decides whether one memory access may use a leaf translation entry. It takes the leaf entry, the kind of access (load, store or instruction fetch), the problem-state bit of the requester, and the key-0 bits of the data and instruction access-mask registers. It works out the set of permissions the page grants. It reports whether the access faults and why. It also builds the syndrome that the storage interrupt handler needs.

The decision is made combinationally and registered once. One cycle after a valid request, a strobe marks the result. A fetch fault carries its cause in an instruction error code. A load or store fault carries its cause in a data syndrome word and captures the faulting effective address. Walking the translation tree and updating the reference and change bits are done elsewhere.

Top module: `radix_perm_check`

## Requirements
- R1: After reset, `resValid`, `fault`, `instFault`, `dataFault`, `grantPerm`, `instErrCode`, `dataSyndrome` and `faultAddr` are all zero.
- R2: `resValid` is high in exactly the cycle after a cycle with `reqValid` high. The result outputs change only on such cycles.
- R3: Entry bits decode into permissions. Bit 2 grants read, bit 1 grants read and write, and bit 0 grants execute. `grantPerm` is ordered {exec, write, read}. In problem state on a page whose bit 3 is clear, this decode is the granted set.
- R4: If bit 3 of the entry (the privileged-page bit) is set and `probState` is high, the granted set is empty.
- R5: In privileged state (`probState` low) on a privileged page, the granted set is the entry decode, and the mask inputs have no effect.
- R6: In privileged state on a non-privileged page, the granted set is the entry decode ANDed with the mask set. `amrKey[1]` (register bit 63) set removes write, `amrKey[0]` (bit 62) set removes read, and `iamrKey` (bit 62) set removes execute.
- R7: Access codes are 0 read, 1 write, 2 execute, and 3 is handled as a read. If the requested permission is not in the granted set, the access faults with cause 0x08000000.
- R8: Entry bits 5:4 form the attribute (00 normal, 01 strongly ordered, 10 non-idempotent I/O, 11 tolerant I/O). A fetch from a 10 page faults with guarded cause 0x10000000 and an empty granted set. The attribute has no effect on loads and stores.
- R9: A fetch fault raises `fault` and `instFault`. It places the cause in `instErrCode`, and leaves `dataSyndrome` and `faultAddr` at zero.
- R10: A load or store fault raises `fault` and `dataFault`. It places the cause in `dataSyndrome`, with bit 25 (0x02000000) also set for a store. It copies `effAddr` into `faultAddr` and leaves `instErrCode` at zero.
- R11: When no fault is found, `fault`, `instFault`, `dataFault`, `instErrCode`, `dataSyndrome` and `faultAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| leafPte | input | PTE_W | Leaf translation entry |
| accType | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| probState | input | 1 | Requester runs in problem (user) state |
| amrKey | input | 2 | Key-0 data mask: [1] denies write, [0] denies read |
| iamrKey | input | 1 | Key-0 instruction mask: denies execute |
| effAddr | input | EA_W | Effective address of the access |
| resValid | output | 1 | Result strobe, one cycle after request |
| grantPerm | output | 3 | Granted set {exec, write, read} |
| fault | output | 1 | Access denied |
| instFault | output | 1 | Denied fetch |
| dataFault | output | 1 | Denied load or store |
| instErrCode | output | ERR_W | Fetch fault cause |
| dataSyndrome | output | ERR_W | Data fault cause with store flag |
| faultAddr | output | EA_W | Captured address of a data fault |

## Verification
The bench builds the block with PTE_W = 64, ERR_W = 32 and EA_W narrowed to 32. The narrower EA_W keeps the captured address readable, and it still leaves every decision-relevant bit in place. At these values the bench can sweep every combination of attribute, privileged bit and access-encoding bits, together with all three access types, both states and every mask value. That covers every corner of the permission and syndrome logic. Filler in the upper entry bits and changing addresses show that only the defined fields steer the result.

// File: rtl/radix_perm_pkg.sv
package radix_perm_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_ALT   = 2'd3
  } accKind_e;

  // Bit positions inside a leaf entry that the decision depends on
  localparam int unsigned PTE_EXEC_BIT = 0;
  localparam int unsigned PTE_RW_BIT   = 1;
  localparam int unsigned PTE_RD_BIT   = 2;
  localparam int unsigned PTE_PRIV_BIT = 3;
  localparam int unsigned PTE_ATT_LO   = 4;
  localparam int unsigned PTE_ATT_HI   = 5;

  localparam logic [1:0] ATT_NONIDEM_IO = 2'b10;

  localparam logic [31:0] CAUSE_PROT    = 32'h0800_0000;
  localparam logic [31:0] CAUSE_GUARDED = 32'h1000_0000;
  localparam logic [31:0] CAUSE_STORE   = 32'h0200_0000;

  // Permission vector order: {exec, write, read}
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic  load;
    logic  isFetch;
    logic  isStore;
    logic  privDeny;
    logic  applyMask;
    logic  guardHit;
    perm_t need;
  } ctrlStrobe_t;

endpackage

// File: rtl/radix_perm_ctrl.sv
module radix_perm_ctrl
  import radix_perm_pkg::*;
#(
  parameter int unsigned PTE_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [PTE_W-1:0] leafPte,
  input  logic [1:0]       accType,
  input  logic             probState,
  output ctrlStrobe_t      strobe,
  output logic             resValid
);

  accKind_e kind;
  logic     pagePriv;
  logic [1:0] attrField;

  always_comb begin
    kind      = accKind_e'(accType);
    pagePriv  = leafPte[PTE_PRIV_BIT];
    attrField = leafPte[PTE_ATT_HI:PTE_ATT_LO];
  end

  always_comb begin
    strobe           = '0;
    strobe.load      = reqValid;
    strobe.isFetch   = (kind == ACC_EXEC);
    strobe.isStore   = (kind == ACC_WRITE);
    strobe.privDeny  = pagePriv && probState;
    strobe.applyMask = !pagePriv && !probState;
    strobe.guardHit  = strobe.isFetch && (attrField == ATT_NONIDEM_IO);
    unique case (kind)
      ACC_WRITE: strobe.need = '{x: 1'b0, w: 1'b1, r: 1'b0};
      ACC_EXEC:  strobe.need = '{x: 1'b1, w: 1'b0, r: 1'b0};
      default:   strobe.need = '{x: 1'b0, w: 1'b0, r: 1'b1};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= reqValid;
  end

endmodule

// File: rtl/radix_perm_datapath.sv
module radix_perm_datapath
  import radix_perm_pkg::*;
#(
  parameter int unsigned PTE_W = 64,
  parameter int unsigned EA_W  = 64,
  parameter int unsigned ERR_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [PTE_W-1:0] leafPte,
  input  logic [1:0]       amrKey,
  input  logic             iamrKey,
  input  logic [EA_W-1:0]  effAddr,
  output logic [2:0]       grantPerm,
  output logic             fault,
  output logic             instFault,
  output logic             dataFault,
  output logic [ERR_W-1:0] instErrCode,
  output logic [ERR_W-1:0] dataSyndrome,
  output logic [EA_W-1:0]  faultAddr
);

  localparam logic [ERR_W-1:0] PROT_C  = ERR_W'(CAUSE_PROT);
  localparam logic [ERR_W-1:0] GUARD_C = ERR_W'(CAUSE_GUARDED);
  localparam logic [ERR_W-1:0] STORE_C = ERR_W'(CAUSE_STORE);

  perm_t eaaPerm, maskPerm, grantNext;
  logic  denied;
  logic [ERR_W-1:0] causeNext;

  always_comb begin
    eaaPerm.r = leafPte[PTE_RD_BIT] | leafPte[PTE_RW_BIT];
    eaaPerm.w = leafPte[PTE_RW_BIT];
    eaaPerm.x = leafPte[PTE_EXEC_BIT];
    maskPerm.r = !amrKey[0];
    maskPerm.w = !amrKey[1];
    maskPerm.x = !iamrKey;
  end

  always_comb begin
    if (strobe.guardHit || strobe.privDeny) grantNext = '0;
    else if (strobe.applyMask)              grantNext = eaaPerm & maskPerm;
    else                                    grantNext = eaaPerm;
    denied = strobe.guardHit || ((strobe.need & grantNext) == '0);
    if (strobe.guardHit) causeNext = GUARD_C;
    else if (denied)     causeNext = PROT_C;
    else                 causeNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantPerm    <= '0;
      fault        <= 1'b0;
      instFault    <= 1'b0;
      dataFault    <= 1'b0;
      instErrCode  <= '0;
      dataSyndrome <= '0;
      faultAddr    <= '0;
    end else if (strobe.load) begin
      grantPerm    <= grantNext;
      fault        <= denied;
      instFault    <= denied && strobe.isFetch;
      dataFault    <= denied && !strobe.isFetch;
      instErrCode  <= (denied && strobe.isFetch) ? causeNext : '0;
      dataSyndrome <= (denied && !strobe.isFetch)
                      ? (causeNext | (strobe.isStore ? STORE_C : '0)) : '0;
      faultAddr    <= (denied && !strobe.isFetch) ? effAddr : '0;
    end
  end

endmodule

// File: rtl/radix_perm_check.sv
module radix_perm_check
  import radix_perm_pkg::*;
#(
  parameter int unsigned PTE_W = 64,
  parameter int unsigned EA_W  = 64,
  parameter int unsigned ERR_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [PTE_W-1:0] leafPte,
  input  logic [1:0]       accType,
  input  logic             probState,
  input  logic [1:0]       amrKey,
  input  logic             iamrKey,
  input  logic [EA_W-1:0]  effAddr,
  output logic             resValid,
  output logic [2:0]       grantPerm,
  output logic             fault,
  output logic             instFault,
  output logic             dataFault,
  output logic [ERR_W-1:0] instErrCode,
  output logic [ERR_W-1:0] dataSyndrome,
  output logic [EA_W-1:0]  faultAddr
);

  ctrlStrobe_t strobe;

  radix_perm_ctrl #(.PTE_W(PTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .leafPte(leafPte),
    .accType(accType), .probState(probState), .strobe(strobe),
    .resValid(resValid)
  );

  radix_perm_datapath #(.PTE_W(PTE_W), .EA_W(EA_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .leafPte(leafPte),
    .amrKey(amrKey), .iamrKey(iamrKey), .effAddr(effAddr),
    .grantPerm(grantPerm), .fault(fault), .instFault(instFault),
    .dataFault(dataFault), .instErrCode(instErrCode),
    .dataSyndrome(dataSyndrome), .faultAddr(faultAddr)
  );

endmodule

// File: rtl/radix_perm_check_sva.sv
module radix_perm_check_sva #(
  parameter int unsigned PTE_W = 64,
  parameter int unsigned EA_W  = 64,
  parameter int unsigned ERR_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [PTE_W-1:0] leafPte,
  input logic [1:0]       accType,
  input logic             probState,
  input logic             resValid,
  input logic [2:0]       grantPerm,
  input logic             fault,
  input logic             instFault,
  input logic             dataFault,
  input logic [ERR_W-1:0] instErrCode,
  input logic [ERR_W-1:0] dataSyndrome,
  input logic [EA_W-1:0]  faultAddr
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);

  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(grantPerm) && $stable(fault) && $stable(dataSyndrome));

  a_r4_priv_page_user: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && leafPte[3] && probState) |=> (grantPerm == 3'b000) && fault);

  a_r8_guarded_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accType == 2'd2 && leafPte[5:4] == 2'b10)
      |=> instFault && (instErrCode == ERR_W'(32'h1000_0000)));

  a_r9_fetch_route: assert property (@(posedge clk) disable iff (!rstN)
    instFault |-> (dataSyndrome == '0) && (faultAddr == '0) && !dataFault);

  a_r10_store_flag: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accType == 2'd1) |=> !fault || dataSyndrome[25]);

  a_r11_clean_pass: assert property (@(posedge clk) disable iff (!rstN)
    !fault |-> (instErrCode == '0) && (dataSyndrome == '0) && (faultAddr == '0));

  a_r9_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({instFault, dataFault}) && (fault == (instFault | dataFault)));

endmodule

bind radix_perm_check radix_perm_check_sva #(
  .PTE_W(PTE_W), .EA_W(EA_W), .ERR_W(ERR_W)
) u_sva (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .leafPte(leafPte),
  .accType(accType), .probState(probState), .resValid(resValid),
  .grantPerm(grantPerm), .fault(fault), .instFault(instFault),
  .dataFault(dataFault), .instErrCode(instErrCode),
  .dataSyndrome(dataSyndrome), .faultAddr(faultAddr)
);

// File: tb/test_radix_perm_check.sv
`timescale 1ns/1ps
module test_radix_perm_check;
  localparam int unsigned PTE_W = 64;
  localparam int unsigned EA_W  = 32;
  localparam int unsigned ERR_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [PTE_W-1:0] leafPte = '0;
  logic [1:0] accType = '0;
  logic probState = 1'b0;
  logic [1:0] amrKey = '0;
  logic iamrKey = 1'b0;
  logic [EA_W-1:0] effAddr = '0;
  logic resValid, fault, instFault, dataFault;
  logic [2:0] grantPerm;
  logic [ERR_W-1:0] instErrCode, dataSyndrome;
  logic [EA_W-1:0] faultAddr;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  radix_perm_check #(.PTE_W(PTE_W), .EA_W(EA_W), .ERR_W(ERR_W)) i_radix_perm_check (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .leafPte(leafPte),
    .accType(accType), .probState(probState), .amrKey(amrKey),
    .iamrKey(iamrKey), .effAddr(effAddr), .resValid(resValid),
    .grantPerm(grantPerm), .fault(fault), .instFault(instFault),
    .dataFault(dataFault), .instErrCode(instErrCode),
    .dataSyndrome(dataSyndrome), .faultAddr(faultAddr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request; results are read 1 ns after the capturing edge
  task automatic runCase(input logic [5:0] low, input logic [1:0] acc,
                         input bit prob, input logic [1:0] amr, input bit iamr,
                         input logic [EA_W-1:0] ea, input logic [57:0] filler);
    logic rd, wr, ex, priv, guard, denied, fetch;
    logic [2:0] exp, need;
    logic [31:0] cause, expI, expD;
    logic [EA_W-1:0] expA;
    string gReq, fReq, rReq;
    @(negedge clk);
    leafPte = {filler, low};
    accType = acc; probState = prob; amrKey = amr; iamrKey = iamr;
    effAddr = ea; reqValid = 1'b1;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    rd = low[2] | low[1]; wr = low[1]; ex = low[0]; priv = low[3];
    fetch = (acc == 2'd2);
    guard = fetch && (low[5:4] == 2'b10);
    if (guard) begin exp = 3'b000; gReq = "R8"; end
    else if (priv && prob) begin exp = 3'b000; gReq = "R4"; end
    else if (priv) begin exp = {ex, wr, rd}; gReq = "R5"; end
    else if (!prob) begin exp = {ex & !iamr, wr & !amr[1], rd & !amr[0]}; gReq = "R6"; end
    else begin exp = {ex, wr, rd}; gReq = "R3"; end
    need = (acc == 2'd1) ? 3'b010 : fetch ? 3'b100 : 3'b001;
    denied = guard || ((need & exp) == 3'b000);
    cause = guard ? 32'h1000_0000 : denied ? 32'h0800_0000 : 32'h0;
    fReq = guard ? "R8" : "R7";
    expI = (denied && fetch) ? cause : 32'h0;
    expD = (denied && !fetch) ? (cause | ((acc == 2'd1) ? 32'h0200_0000 : 32'h0)) : 32'h0;
    expA = (denied && !fetch) ? ea : '0;
    rReq = !denied ? "R11" : fetch ? "R9" : "R10";
    check(resValid === 1'b1, "R2", 64'(resValid), 64'd1);
    check(grantPerm === exp, gReq, 64'(grantPerm), 64'(exp));
    check(fault === denied, fReq, 64'(fault), 64'(denied));
    check({instFault, dataFault} === {denied && fetch, denied && !fetch}, rReq,
          64'({instFault, dataFault}), 64'({denied && fetch, denied && !fetch}));
    check(instErrCode === expI, rReq, 64'(instErrCode), 64'(expI));
    check(dataSyndrome === expD, rReq, 64'(dataSyndrome), 64'(expD));
    check(faultAddr === expA, rReq, 64'(faultAddr), 64'(expA));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] heldPerm;
    logic [31:0] heldSyn;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check({resValid, fault, instFault, dataFault, grantPerm} === 7'b0, "R1",
          64'({resValid, fault, instFault, dataFault, grantPerm}), 64'd0);
    check(instErrCode === '0 && dataSyndrome === '0 && faultAddr === '0, "R1",
          64'(dataSyndrome), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // Full sweep over decision-relevant fields
    for (int att = 0; att < 4; att++)
      for (int eaa = 0; eaa < 16; eaa++)
        for (int acc = 0; acc < 3; acc++)
          for (int pr = 0; pr < 2; pr++)
            for (int am = 0; am < 4; am++)
              for (int im = 0; im < 2; im++)
                runCase({2'(att), 4'(eaa)}, 2'(acc), pr[0], 2'(am), im[0],
                        32'hC000_0000 ^ 32'(att * 4099 + eaa * 131 + acc * 17 + am),
                        58'h2AA_5555_0000_0F0F ^ 58'(eaa * 977));

    // Access code 3 behaves as a read (R7)
    runCase(6'b000100, 2'd3, 1'b1, 2'b00, 1'b0, 32'h1234_5678, '0);
    runCase(6'b000001, 2'd3, 1'b1, 2'b00, 1'b0, 32'h1234_5678, '0);

    // Idle cycle: strobe drops and results hold (R2)
    runCase(6'b000001, 2'd0, 1'b0, 2'b00, 1'b0, 32'hDEAD_BEEF, '0);
    heldPerm = grantPerm;
    heldSyn = dataSyndrome;
    @(negedge clk);
    leafPte = 64'h3F; accType = 2'd2;
    @(posedge clk);
    #1;
    check(resValid === 1'b0, "R2", 64'(resValid), 64'd0);
    check(grantPerm === heldPerm && dataSyndrome === heldSyn, "R2",
          64'(dataSyndrome), 64'(heldSyn));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule